// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received frame should be kept, based only on its 48-bit destination address. A frame is kept in any of these cases:

- its address equals one of sixteen programmable exact entries;
- it is a group address whose 12-bit hash selects a set bit in a 4096-bit table;
- it is the all-ones broadcast address and broadcast acceptance is enabled;
- a promiscuous control admits it.

Every lookup returns an accept flag together with a reason code, so the downstream datapath can tell why the frame was admitted.

Software programs the block with single-cycle 32-bit register writes. The writes cover three things: a control word, the hash table (128 words), and the exact entries (a low word and a high word each).

The frame side is a valid/ready stream:

- An address is taken on a cycle where `da_valid` and `da_ready` are both high.
- Its result appears on `res_valid` one cycle later and stays stable until `res_ready` is high.
- `da_ready` is high whenever the result register is empty or is being drained in the same cycle. A stalled consumer therefore stalls the producer with no extra buffering.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset, `res_valid` is 0, `da_ready` is 1, all exact entries are invalid, every hash table bit is 0 and every control bit is 0, so any lookup is rejected.
- R2: An exact entry holds address bytes 0..3 in its low word (address byte 0 in bits 7:0) and bytes 4..5 in bits 15:0 of its high word. Address byte k is `da_addr[8k+7:8k]`. Entry i low word is at byte address 0x400+8i and its high word at 0x404+8i. A valid entry equal to the whole 48-bit address gives accept 1 with reason EXACT (code 1).
- R3: Bit 31 of an entry's high word is its valid bit; an entry with that bit 0 never matches, whatever address it holds.
- R4: The hash index is `da_addr[47:36]`: word index = index[11:5], bit index = index[4:0]. Hash word n is at byte address 0x200+4n. A group address (`da_addr[0]`=1) whose bit is set gives accept 1 with reason HASH (code 2). The offset field, control bits 13:12, has no effect on the selected bit.
- R5: Control bit 3 (unicast promiscuous) admits any individual address (`da_addr[0]`=0) with reason PROMISC (code 4). It does not admit group addresses.
- R6: Control bit 4 (multicast promiscuous) admits any group address with reason PROMISC (code 4). It does not admit individual addresses.
- R7: The all-ones address is accepted, with reason BCAST (code 3), if and only if control bit 15 is set. Exact, hash and promiscuous settings do not change this. The control word is at byte address 0x000.
- R8: For a non-broadcast address the reason priority is EXACT, then HASH, then PROMISC.
- R9: A lookup that no rule admits gives accept 0 with reason REJECT (code 0); accept is 1 exactly when the reason is not REJECT.
- R10: A result is presented the cycle after its handshake and stays unchanged while `res_valid` is 1 and `res_ready` is 0. `da_ready` equals `!res_valid || res_ready`.
- R11: A register write in the same cycle as an address handshake affects only later lookups; that lookup sees the contents before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| da_valid | input | 1 | Destination address valid |
| da_ready | output | 1 | Filter can take an address |
| da_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_accept | output | 1 | Frame accepted |
| res_reason | output | 3 | 0 reject, 1 exact, 2 hash, 3 broadcast, 4 promiscuous |

## Verification
Each admission path is tried in isolation and then in conflict with the others:

- Exact, hash and promiscuous matches are checked one at a time.
- Broadcast is tried with every other path also enabled. This separates a correct broadcast gate from one that lets the exact entry or the hash bit win.
- A group address is matched both exactly and through the hash, which exposes a wrong priority order.
- Single-bit changes of a matching address, and hash indices 0x000 and 0xFFF, catch off-by-one compares and bit-order mistakes.
- A stretch of random addresses drawn from a pool, with random consumer stalls and interleaved register writes, separates correct hold-under-back-pressure and write-versus-lookup ordering from variants that lose or recompute a pending result.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int MAC_W = 48;

  typedef enum logic [2:0] {
    RSN_REJECT  = 3'd0,
    RSN_EXACT   = 3'd1,
    RSN_HASH    = 3'd2,
    RSN_BCAST   = 3'd3,
    RSN_PROMISC = 3'd4
  } rxf_reason_e;

  typedef struct packed {
    logic bcast_ok;
    logic mc_prom;
    logic uc_prom;
  } rxf_ctl_t;

  // Control word bit positions
  localparam int CTL_UC_PROM_BIT = 3;
  localparam int CTL_MC_PROM_BIT = 4;
  localparam int CTL_BCAST_BIT   = 15;

endpackage

// File: rtl/rxf_exact_bank.sv
module rxf_exact_bank #(
  parameter int N_ENTRY = 16,
  localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic                     wr_hi,
  input  logic [31:0]              wr_data,
  input  logic                     wr_vld,
  input  logic [rxf_pkg::MAC_W-1:0] lookup_addr,
  output logic                     hit_any
);

  logic [N_ENTRY-1:0] hit;

  for (genvar gi = 0; gi < N_ENTRY; gi++) begin : g_entry
    logic [31:0] lo_q;
    logic [15:0] hi_q;
    logic        vld_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q  <= '0;
        hi_q  <= '0;
        vld_q <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
        if (wr_hi) begin
          hi_q  <= wr_data[15:0];
          vld_q <= wr_vld;
        end else begin
          lo_q <= wr_data;
        end
      end
    end

    assign hit[gi] = vld_q && ({hi_q, lo_q} == lookup_addr);

    AST_INVALID_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_hi && (wr_idx == IDX_W'(gi)) && !wr_vld) |=> !hit[gi]); // R3
  end

  assign hit_any = |hit;

endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table #(
  parameter int HASH_BITS = 12,
  localparam int N_BITS   = 1 << HASH_BITS,
  localparam int N_WORDS  = N_BITS / 32,
  localparam int WIDX_W   = $clog2(N_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [WIDX_W-1:0]    wr_word,
  input  logic [31:0]          wr_data,
  input  logic [HASH_BITS-1:0] lookup_idx,
  output logic                 bit_set
);

  logic [31:0] words_q [N_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < N_WORDS; w++) words_q[w] <= '0;
    end else if (wr_en) begin
      words_q[wr_word] <= wr_data;
    end
  end

  logic [WIDX_W-1:0] rd_word;
  logic [4:0]        rd_bit;

  assign rd_word = lookup_idx[HASH_BITS-1:5];
  assign rd_bit  = lookup_idx[4:0];
  assign bit_set = words_q[rd_word][rd_bit];

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  logic [MAC_W-1:0] addr,
  input  logic             exact_hit,
  input  logic             hash_hit,
  input  rxf_ctl_t         ctl,
  output logic             accept,
  output rxf_reason_e      reason
);

  logic is_bcast;
  logic is_group;

  assign is_bcast = &addr;
  assign is_group = addr[0];

  always_comb begin
    if (is_bcast)
      accept = ctl.bcast_ok;
    else if (is_group)
      accept = exact_hit | hash_hit | ctl.mc_prom;
    else
      accept = exact_hit | ctl.uc_prom;
  end

  always_comb begin
    reason = RSN_REJECT;
    if (is_bcast) begin
      if (ctl.bcast_ok) reason = RSN_BCAST;
    end else if (exact_hit) begin
      reason = RSN_EXACT;
    end else if (is_group) begin
      if (hash_hit)         reason = RSN_HASH;
      else if (ctl.mc_prom) reason = RSN_PROMISC;
    end else if (ctl.uc_prom) begin
      reason = RSN_PROMISC;
    end
  end

endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
  import rxf_pkg::*;
#(
  parameter int N_EXACT   = 16,
  parameter int HASH_BITS = 12,
  parameter int ADDR_W    = 12,
  parameter int CTL_ADDR  = 'h000,
  parameter int TBL_BASE  = 'h200,
  parameter int EX_BASE   = 'h400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [11:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        da_valid,
  output logic        da_ready,
  input  logic [47:0] da_addr,
  output logic        res_valid,
  input  logic        res_ready,
  output logic        res_accept,
  output logic [2:0]  res_reason
);

  localparam int N_WORDS = (1 << HASH_BITS) / 32;
  localparam int WIDX_W  = $clog2(N_WORDS);
  localparam int EIDX_W  = (N_EXACT > 1) ? $clog2(N_EXACT) : 1;
  localparam int TBL_END = TBL_BASE + N_WORDS * 4;
  localparam int EX_END  = EX_BASE + N_EXACT * 8;

  // ---------------- register decode ----------------
  logic              sel_ctl, sel_tbl, sel_ex;
  logic [ADDR_W-1:0] tbl_off, ex_off;

  assign sel_ctl = cfg_wr_en && (cfg_addr == ADDR_W'(CTL_ADDR));
  assign sel_tbl = cfg_wr_en && (cfg_addr >= ADDR_W'(TBL_BASE)) && (32'(cfg_addr) < TBL_END);
  assign sel_ex  = cfg_wr_en && (cfg_addr >= ADDR_W'(EX_BASE))  && (32'(cfg_addr) < EX_END);
  assign tbl_off = cfg_addr - ADDR_W'(TBL_BASE);
  assign ex_off  = cfg_addr - ADDR_W'(EX_BASE);

  rxf_ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (sel_ctl) begin
      ctl_q.uc_prom  <= cfg_wdata[CTL_UC_PROM_BIT];
      ctl_q.mc_prom  <= cfg_wdata[CTL_MC_PROM_BIT];
      ctl_q.bcast_ok <= cfg_wdata[CTL_BCAST_BIT];
    end
  end

  // ---------------- lookup structures ----------------
  logic exact_hit, hash_hit;

  rxf_exact_bank #(.N_ENTRY(N_EXACT)) u_exact (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (sel_ex),
    .wr_idx     (ex_off[EIDX_W+2:3]),
    .wr_hi      (ex_off[2]),
    .wr_data    (cfg_wdata),
    .wr_vld     (cfg_wdata[31]),
    .lookup_addr(da_addr),
    .hit_any    (exact_hit)
  );

  rxf_hash_table #(.HASH_BITS(HASH_BITS)) u_hash (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (sel_tbl),
    .wr_word   (tbl_off[WIDX_W+1:2]),
    .wr_data   (cfg_wdata),
    .lookup_idx(da_addr[MAC_W-1 -: HASH_BITS]),
    .bit_set   (hash_hit)
  );

  logic        dec_accept;
  rxf_reason_e dec_reason;

  rxf_decide u_decide (
    .addr     (da_addr),
    .exact_hit(exact_hit),
    .hash_hit (hash_hit),
    .ctl      (ctl_q),
    .accept   (dec_accept),
    .reason   (dec_reason)
  );

  // ---------------- result stage ----------------
  logic fire;

  assign da_ready = !res_valid || res_ready;
  assign fire     = da_valid && da_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_reason <= RSN_REJECT;
    end else if (fire) begin
      res_valid  <= 1'b1;
      res_accept <= dec_accept;
      res_reason <= dec_reason;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && da_ready) |=> res_valid); // R10

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_accept) && $stable(res_reason))); // R10

  AST_ACCEPT_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_accept == (res_reason != 3'(RSN_REJECT)))); // R9

  AST_BCAST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && da_ready && (&da_addr) && !ctl_q.bcast_ok) |=> !res_accept); // R7

endmodule

// File: tb/rxf_addr_filter_tb.sv
module rxf_addr_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        da_valid = 1'b0;
  logic [47:0] da_addr = '0;
  logic        res_ready = 1'b1;
  logic        da_ready, res_valid, res_accept;
  logic [2:0]  res_reason;

  always #5 clk = ~clk;

  rxf_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .da_valid(da_valid), .da_ready(da_ready), .da_addr(da_addr),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_accept(res_accept), .res_reason(res_reason)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_lo  [16];
  logic [31:0] m_hi  [16];
  logic [31:0] m_tbl [128];
  logic [31:0] m_ctl;
  bit          m_valid;
  bit          m_acc;
  logic [2:0]  m_rsn;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string tag    = "R1";

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    for (int i = 0; i < 128; i++) m_tbl[i] = '0;
    m_ctl = '0; m_valid = 0; m_acc = 0; m_rsn = 0;
  endtask

  task automatic ref_eval(input logic [47:0] a, output bit acc, output logic [2:0] rsn);
    bit ex = 0;
    bit hb;
    int idx;
    for (int i = 0; i < 16; i++)
      if (m_hi[i][31] && ({m_hi[i][15:0], m_lo[i]} == a)) ex = 1;
    idx = int'(a[47:36]);
    hb  = m_tbl[idx / 32][idx % 32];
    if (a == 48'hFFFF_FFFF_FFFF) begin
      acc = m_ctl[15]; rsn = acc ? 3'd3 : 3'd0;
    end else if (ex) begin
      acc = 1; rsn = 3'd1;
    end else if (a[0]) begin
      if (hb)            begin acc = 1; rsn = 3'd2; end
      else if (m_ctl[4]) begin acc = 1; rsn = 3'd4; end
      else               begin acc = 0; rsn = 3'd0; end
    end else begin
      if (m_ctl[3]) begin acc = 1; rsn = 3'd4; end
      else          begin acc = 0; rsn = 3'd0; end
    end
  endtask

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    int ia = int'(a);
    if (ia == 0) m_ctl = d;
    else if (ia >= 'h200 && ia < 'h400) m_tbl[(ia - 'h200) / 4] = d;
    else if (ia >= 'h400 && ia < 'h480) begin
      if (ia[2]) m_hi[(ia - 'h400) / 8] = d;
      else       m_lo[(ia - 'h400) / 8] = d;
    end
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: model follows the posedge, outputs compared at the negedge
  task automatic step();
    bit hs;
    bit acc;
    logic [2:0] rsn;
    hs = da_valid && (!m_valid || res_ready);
    @(posedge clk);
    if (!rst_n) model_reset();
    else begin
      if (hs) begin
        ref_eval(da_addr, acc, rsn);
        m_valid = 1; m_acc = acc; m_rsn = rsn;
      end else if (res_ready) m_valid = 0;
      if (cfg_wr_en) model_write(cfg_addr, cfg_wdata);
    end
    @(negedge clk);
    chk("res_valid", 32'(res_valid), 32'(m_valid));
    chk("da_ready", 32'(da_ready), 32'(!m_valid || res_ready));
    if (m_valid) begin
      chk("res_accept", 32'(res_accept), 32'(m_acc));
      chk("res_reason", 32'(res_reason), 32'(m_rsn));
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_wr_en = 0;
  endtask

  task automatic set_entry(input int i, input logic [47:0] a, input bit v);
    wr(12'(32'h400 + 8 * i), a[31:0]);
    wr(12'(32'h404 + 8 * i), {v, 15'h0, a[47:32]});
  endtask

  task automatic set_hash(input logic [47:0] a);
    int idx = int'(a[47:36]);
    wr(12'(32'h200 + 4 * (idx / 32)), m_tbl[idx / 32] | (32'h1 << (idx % 32)));
  endtask

  // lookup with consumer ready; result compared by step()
  task automatic look(input logic [47:0] a);
    da_valid = 1; da_addr = a;
    step();
    da_valid = 0;
    step();
  endtask

  // explicit expected-value check of the last result
  task automatic expect_res(input bit acc, input logic [2:0] rsn);
    chk("exp_accept", 32'(res_accept), 32'(acc));
    chk("exp_reason", 32'(res_reason), 32'(rsn));
  endtask

  // checks the most recent result, which sits one step before the drain step
  task automatic look_exp(input logic [47:0] a, input bit acc, input logic [2:0] rsn);
    da_valid = 1; da_addr = a;
    step();
    da_valid = 0;
    expect_res(acc, rsn);
    step();
  endtask

  initial begin
    automatic int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  localparam logic [47:0] UA = 48'h5544_3322_1100; // unicast, byte0 0x00
  localparam logic [47:0] UB = 48'hA1B2_C3D4_E5F6;
  localparam logic [47:0] GM = 48'h3C70_0000_5E01; // group, idx 0x3C7
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

  initial begin
    model_reset();
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step();

    tag = "R1";
    chk("R1 reset res_valid", 32'(res_valid), 0);
    chk("R1 reset da_ready", 32'(da_ready), 1);
    look_exp(48'h0, 0, 3'd0);
    look_exp(GM, 0, 3'd0);
    look_exp(BC, 0, 3'd0);

    tag = "R2";
    set_entry(0, UA, 1);
    look_exp(UA, 1, 3'd1);
    set_entry(15, UB, 1);
    look_exp(UB, 1, 3'd1);

    tag = "R9";
    look_exp(UA ^ 48'h0000_0000_0100, 0, 3'd0);
    look_exp(UA ^ 48'h8000_0000_0000, 0, 3'd0);

    tag = "R3";
    set_entry(5, 48'h0A0B_0C0D_0E10, 0);
    look_exp(48'h0A0B_0C0D_0E10, 0, 3'd0);
    set_entry(5, 48'h0A0B_0C0D_0E10, 1);
    look_exp(48'h0A0B_0C0D_0E10, 1, 3'd1);

    tag = "R4";
    set_hash(GM);
    look_exp(GM, 1, 3'd2);
    look_exp(GM ^ 48'h0010_0000_0000, 0, 3'd0);
    set_hash(48'h0000_0000_0001);
    look_exp(48'h000F_1234_5601, 1, 3'd2);
    set_hash(48'hFFF0_0000_0000);
    look_exp(48'hFFFF_FFFF_FFF1, 1, 3'd2);
    look_exp(48'hFFE0_0000_0001, 0, 3'd0);
    wr(12'h000, 32'h0000_3000);
    look_exp(GM, 1, 3'd2);
    look_exp(48'h3C60_0000_0001, 0, 3'd0);

    tag = "R5";
    wr(12'h000, 32'h0000_0008);
    look_exp(48'h1234_5678_9A00, 1, 3'd4);
    look_exp(48'h1234_5678_9A01, 0, 3'd0);

    tag = "R6";
    wr(12'h000, 32'h0000_0010);
    look_exp(48'h1234_5678_9A01, 1, 3'd4);
    look_exp(48'h1234_5678_9A00, 0, 3'd0);

    tag = "R7";
    set_entry(3, BC, 1);
    wr(12'h000, 32'h0000_0018);
    look_exp(BC, 0, 3'd0);
    wr(12'h000, 32'h0000_8000);
    look_exp(BC, 1, 3'd3);

    tag = "R8";
    set_entry(7, GM, 1);
    wr(12'h000, 32'h0000_0018);
    look_exp(GM, 1, 3'd1);
    look_exp(UA, 1, 3'd1);
    set_entry(8, 48'h0000_0000_0001, 1);
    look_exp(48'h0000_0000_0001, 1, 3'd1);

    tag = "R10";
    res_ready = 0;
    da_valid = 1; da_addr = UA;
    step();
    da_addr = UB;
    for (int k = 0; k < 4; k++) step();
    chk("R10 held da_ready", 32'(da_ready), 0);
    expect_res(1, 3'd1);
    res_ready = 1;
    step();
    da_valid = 0;
    step(); step();

    tag = "R11";
    da_valid = 1; da_addr = UA;
    cfg_wr_en = 1; cfg_addr = 12'h404; cfg_wdata = 32'h0000_5544;
    step();
    cfg_wr_en = 0; da_valid = 0;
    expect_res(1, 3'd1);
    step();
    wr(12'h000, 32'h0);
    look_exp(UA, 0, 3'd0);

    tag = "R10";
    for (int k = 0; k < 400; k++) begin
      int sel = $urandom_range(0, 6);
      case (sel)
        0: da_addr = UA;
        1: da_addr = UB;
        2: da_addr = GM;
        3: da_addr = BC;
        4: da_addr = 48'h3C70_0000_0001;
        5: da_addr = {36'h0, 12'h0} | 48'(32'($urandom()));
        default: da_addr = {16'($urandom()), 32'($urandom())};
      endcase
      da_valid  = $urandom_range(0, 3) != 0;
      res_ready = $urandom_range(0, 2) != 0;
      if ($urandom_range(0, 7) == 0) begin
        cfg_wr_en = 1;
        case ($urandom_range(0, 2))
          0: begin cfg_addr = 12'h000; cfg_wdata = $urandom() & 32'h0000_8018; end
          1: begin cfg_addr = 12'(32'h200 + 4 * $urandom_range(0, 127)); cfg_wdata = $urandom(); end
          default: begin cfg_addr = 12'(32'h400 + 4 * $urandom_range(0, 31)); cfg_wdata = $urandom(); end
        endcase
      end
      step();
      cfg_wr_en = 0;
    end
    da_valid = 0; res_ready = 1;
    step(); step();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule